// File: doc/BRIEF.md
# Chained Transmit Command Queue

This block sits between a host processor and a token-passing transmitter. The host posts transmit commands, each naming a packet page, and the block holds up to two of them. A second transmission can therefore be queued while the first is still waiting for the token or still on the wire. Each time the token arrives and nothing is in flight, the oldest queued command is launched through a start/done/ack handshake with the transmitter.

Completion results go into a two-deep status queue. The visible status is a transmit-done flag and an acknowledge-result flag, and it always shows the oldest result the host has not yet cleared. A later result stays hidden until the host issues a clear command. A maskable level interrupt follows the transmit-done flag. After every deassertion the interrupt is held low for a minimum number of cycles, so each completion produces its own edge. A disable command removes only the oldest pending command. If that command is in flight, its transmission is abandoned.

Commands arrive on one bus as a 2-bit operation code. The codes are 1 for queue-transmit, 2 for clear-status and 3 for disable-oldest. Code 0 does nothing.

Top module: `tx_chain_queue`

## Requirements
- R1: After reset, stat_done, stat_ack, irq, overflow and tx_start are 0, and pend_cnt is 0.
- R2: A queue-transmit command (op 1) is accepted while fewer than QDEPTH commands are pending, and pend_cnt rises by one on the next cycle.
- R3: A queue-transmit command that arrives while QDEPTH commands are pending is dropped. pend_cnt is unchanged, and overflow is high for exactly the one following cycle.
- R4: A token pulse starts the oldest pending command when all of the following hold: nothing is in flight, a command is pending, the status queue has room, and no disable arrives in the same cycle. tx_start is then high for one cycle, on the cycle after the token, and tx_page carries that command's page. A token arriving while a command is in flight is ignored.
- R5: A tx_done pulse while a command is in flight retires that command, lowering pend_cnt, and queues the tx_ack value as its result. A tx_done pulse with nothing in flight has no effect.
- R6: The visible status shows the oldest uncleared result and does not change until a clear command (op 2). The clear exposes the next queued result, if there is one, on the following cycle.
- R7: stat_ack is 0 whenever stat_done is 0.
- R8: irq rises one cycle after stat_done is high with done_irq_en set, provided the low gap has elapsed. irq falls on the cycle after a clear command.
- R9: Once irq has fallen, it stays low for exactly MIN_LOW_CYC cycles before it can rise again while a result is still waiting.
- R10: With done_irq_en low, irq stays low while stat_done still reports completions.
- R11: A disable command (op 3) removes the oldest pending command, abandoning it if it is in flight, so that its later tx_done is ignored. Two disables empty a full queue. A disable with nothing pending has no effect.
- R12: stat_done becomes 1 only through a completed transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 queue-transmit, 2 clear-status, 3 disable-oldest |
| cmd_page | input | PAGE_W | Page named by a queue-transmit command |
| done_irq_en | input | 1 | Enables the transmit-done interrupt |
| token | input | 1 | Token-arrival pulse |
| tx_done | input | 1 | Transmission-finished pulse |
| tx_ack | input | 1 | Acknowledge outcome, valid with tx_done |
| tx_start | output | 1 | One-cycle start request to the transmitter |
| tx_page | output | PAGE_W | Page of the transmission being started |
| stat_done | output | 1 | Transmit-done status flag |
| stat_ack | output | 1 | Acknowledge result of the shown completion |
| irq | output | 1 | Level interrupt request |
| overflow | output | 1 | One-cycle flag for a dropped queue-transmit |
| pend_cnt | output | $clog2(QDEPTH+1) | Number of pending commands |

## Verification
The assertions check the following on every cycle: the single-cycle overflow and start pulses, count preservation on overflow, the count drop on a disable, status stability between clears, irq dropping after a clear and staying low under the mask, and the minimum low run before any re-assertion, measured by a counter in the checker. The bench scenarios are needed to show that pages come out in command order and that the second result appears only after the first is cleared. They also show the exact length of the gap, that stray tx_done pulses and the done pulse of an abandoned transmission are ignored, and that a disable removes the oldest entry rather than the newest.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_SEND  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_DROP  = 2'd3
  } txq_op_e;

  // Cycles the pacer counter is loaded with on an irq fall, given the required low run.
  function automatic int unsigned gap_reload(int unsigned min_low);
    return (min_low > 0) ? min_low - 1 : 0;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_step(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/txq_irq_pacer.sv
module txq_irq_pacer
  import txq_pkg::*;
#(
  parameter int MIN_LOW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic drop,
  output logic irq
);
  localparam int GW = $clog2(MIN_LOW+1);

  logic [GW-1:0] gap;
  logic          irq_nxt;

  assign irq_nxt = req && !drop && (gap == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      gap <= '0;
    end else begin
      irq <= irq_nxt;
      if (irq && !irq_nxt) gap <= GW'(gap_reload(MIN_LOW));
      else if (gap != '0)  gap <= gap - GW'(1);
    end
  end
endmodule

// File: rtl/tx_chain_queue.sv
module tx_chain_queue
  import txq_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int QDEPTH      = 2,
  parameter int MIN_LOW_CYC = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [1:0]                    cmd_op,
  input  logic [PAGE_W-1:0]             cmd_page,
  input  logic                          done_irq_en,
  input  logic                          token,
  input  logic                          tx_done,
  input  logic                          tx_ack,
  output logic                          tx_start,
  output logic [PAGE_W-1:0]             tx_page,
  output logic                          stat_done,
  output logic                          stat_ack,
  output logic                          irq,
  output logic                          overflow,
  output logic [$clog2(QDEPTH+1)-1:0]   pend_cnt
);
  localparam int CW = $clog2(QDEPTH+1);

  // Named internal events, observed by the bound checker.
  logic is_send, is_clear, is_drop;
  logic ev_accept, ev_ovf, ev_start, ev_done, ev_cancel, ev_clear;
  logic cq_pop;
  logic inflight;

  logic [PAGE_W-1:0] cq_head;
  logic              cq_full, cq_empty;
  logic [0:0]        sq_head;
  logic [CW-1:0]     sq_count;
  logic              sq_full, sq_empty;

  assign is_send  = cmd_valid && (cmd_op == OP_SEND);
  assign is_clear = cmd_valid && (cmd_op == OP_CLEAR);
  assign is_drop  = cmd_valid && (cmd_op == OP_DROP);

  assign ev_accept = is_send && !cq_full;
  assign ev_ovf    = is_send && cq_full;
  assign ev_done   = tx_done && inflight;
  assign ev_cancel = is_drop && !cq_empty && !ev_done;
  assign ev_start  = token && !inflight && !cq_empty && !sq_full && !is_drop;
  assign ev_clear  = is_clear && !sq_empty;
  assign cq_pop    = ev_done || ev_cancel;

  txq_fifo #(.W(PAGE_W), .DEPTH(QDEPTH)) u_cmdq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_accept),
    .din   (cmd_page),
    .pop   (cq_pop),
    .head  (cq_head),
    .count (pend_cnt),
    .full  (cq_full),
    .empty (cq_empty)
  );

  txq_fifo #(.W(1), .DEPTH(QDEPTH)) u_statq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_done),
    .din   (tx_ack),
    .pop   (ev_clear),
    .head  (sq_head),
    .count (sq_count),
    .full  (sq_full),
    .empty (sq_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      tx_start <= 1'b0;
      tx_page  <= '0;
      overflow <= 1'b0;
    end else begin
      tx_start <= ev_start;
      overflow <= ev_ovf;
      if (ev_start) begin
        inflight <= 1'b1;
        tx_page  <= cq_head;
      end else if (ev_done || (ev_cancel && inflight)) begin
        inflight <= 1'b0;
      end
    end
  end

  assign stat_done = !sq_empty;
  assign stat_ack  = !sq_empty && sq_head[0];

  txq_irq_pacer #(.MIN_LOW(MIN_LOW_CYC)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (stat_done && done_irq_en),
    .drop  (ev_clear),
    .irq   (irq)
  );
endmodule

// File: rtl/tx_chain_queue_chk.sv
module tx_chain_queue_chk #(
  parameter int PAGE_W      = 4,
  parameter int QDEPTH      = 2,
  parameter int MIN_LOW_CYC = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        token,
  input logic                        done_irq_en,
  input logic                        tx_start,
  input logic                        stat_done,
  input logic                        stat_ack,
  input logic                        irq,
  input logic                        overflow,
  input logic [$clog2(QDEPTH+1)-1:0] pend_cnt,
  input logic                        ev_ovf,
  input logic                        ev_done,
  input logic                        ev_cancel,
  input logic                        ev_clear,
  input logic                        cq_pop
);
  logic [15:0] low_run;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run   <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (irq) low_run <= '0;
      else if (low_run != 16'hffff) low_run <= low_run + 16'd1;
      if ($fell(irq)) seen_fall <= 1'b1;
    end
  end

  a_r3_overflow_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> overflow);
  a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(ev_ovf));
  a_r3_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf && !cq_pop |=> pend_cnt == $past(pend_cnt));
  a_r4_start_after_token: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(token));
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  a_r5_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> stat_done);
  a_r6_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done && !ev_clear |=> stat_done && (stat_ack == $past(stat_ack)));
  a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> !irq);
  a_r9_min_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && seen_fall |-> low_run >= 16'(MIN_LOW_CYC));
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !done_irq_en |=> !irq);
  a_r11_cancel_pops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> pend_cnt == $past(pend_cnt) - 1'b1);
  a_r12_done_only_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_done) |-> $past(ev_done));
endmodule

bind tx_chain_queue tx_chain_queue_chk #(
  .PAGE_W(PAGE_W), .QDEPTH(QDEPTH), .MIN_LOW_CYC(MIN_LOW_CYC)
) u_chk (.*);

// File: tb/sim_tx_chain_queue.sv
module sim_tx_chain_queue;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_page = 4'd0;
  logic       done_irq_en = 1'b1;
  logic       token = 1'b0;
  logic       tx_done = 1'b0;
  logic       tx_ack = 1'b0;
  logic       tx_start;
  logic [3:0] tx_page;
  logic       stat_done, stat_ack, irq, overflow;
  logic [1:0] pend_cnt;

  int n_total = 0;
  int n_fail  = 0;
  bit fin     = 1'b0;
  int exp_pages[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_chain_queue #(.PAGE_W(4), .QDEPTH(2), .MIN_LOW_CYC(MIN_LOW)) u0 (.*);

  task automatic check(string req, int act, int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(int op, int page);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_page = 4'(page);
    cyc();
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  // Driver side of the scoreboard: a token that should launch records the expected page.
  task automatic give_token(int expect_page);
    if (expect_page >= 0) exp_pages.push_back(expect_page);
    token = 1'b1;
    cyc();
    token = 1'b0;
  endtask

  task automatic finish_tx(bit ack);
    tx_done = 1'b1; tx_ack = ack;
    cyc();
    tx_done = 1'b0; tx_ack = 1'b0;
  endtask

  // Monitor side: every start is compared with the oldest expected page.
  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      if (exp_pages.size() == 0) check("R4 unexpected start", 1, 0);
      else check("R4 start page order", int'(tx_page), exp_pages.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int n_low;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 stat_done", int'(stat_done), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 pend_cnt", int'(pend_cnt), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 tx_start", int'(tx_start), 0);

    cmd(1, 3);
    check("R2 pend after first", int'(pend_cnt), 1);
    cmd(1, 5);
    check("R2 pend after second", int'(pend_cnt), 2);
    cmd(1, 7);
    check("R3 overflow flag", int'(overflow), 1);
    check("R3 pend unchanged", int'(pend_cnt), 2);
    cyc();
    check("R3 overflow one cycle", int'(overflow), 0);

    give_token(3);
    check("R4 tx_start pulse", int'(tx_start), 1);
    cyc();
    check("R4 tx_start drops", int'(tx_start), 0);
    give_token(-1);
    check("R4 token ignored in flight", int'(tx_start), 0);

    finish_tx(1'b1);
    check("R5 stat_done set", int'(stat_done), 1);
    check("R5 stat_ack", int'(stat_ack), 1);
    check("R5 entry retired", int'(pend_cnt), 1);
    cyc();
    check("R8 irq rises", int'(irq), 1);

    give_token(5);
    cyc();
    finish_tx(1'b0);
    check("R6 first result kept ack", int'(stat_ack), 1);
    check("R6 done still shown", int'(stat_done), 1);
    check("R5 queue empty", int'(pend_cnt), 0);

    cmd(2, 0);
    check("R8 irq falls on clear", int'(irq), 0);
    check("R6 second result shown", int'(stat_done), 1);
    check("R6 second ack", int'(stat_ack), 0);
    n_low = 1;
    while (!irq && n_low < 50) begin
      cyc();
      if (!irq) n_low++;
    end
    check("R9 low gap length", n_low, MIN_LOW);

    cmd(2, 0);
    check("R7 stat_done cleared", int'(stat_done), 0);
    check("R7 stat_ack zero", int'(stat_ack), 0);
    cyc();
    check("R8 irq stays low", int'(irq), 0);

    done_irq_en = 1'b0;
    cmd(1, 9);
    give_token(9);
    cyc();
    finish_tx(1'b1);
    repeat (MIN_LOW + 2) cyc();
    check("R10 status still set", int'(stat_done), 1);
    check("R10 irq masked", int'(irq), 0);
    cmd(2, 0);
    done_irq_en = 1'b1;

    finish_tx(1'b1);
    check("R5 stray done ignored", int'(stat_done), 0);
    check("R12 no status without tx", int'(irq), 0);

    cmd(1, 1);
    cmd(1, 2);
    cmd(3, 0);
    check("R11 disable pops one", int'(pend_cnt), 1);
    give_token(2);
    cyc();
    cmd(3, 0);
    check("R11 in-flight cancelled", int'(pend_cnt), 0);
    finish_tx(1'b1);
    check("R11 abandoned done ignored", int'(stat_done), 0);
    cmd(3, 0);
    check("R11 disable on empty", int'(pend_cnt), 0);
    cmd(1, 4);
    cmd(1, 6);
    cmd(3, 0);
    cmd(3, 0);
    check("R11 two disables empty queue", int'(pend_cnt), 0);

    repeat (2) cyc();
    check("R4 all starts seen", exp_pages.size(), 0);
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule